// File: doc/BRIEF.md
# Hit Stretcher and Sector Fast-OR

This block sits between a bank of discriminator outputs and the trigger-latency storage of a tracking front end. Each channel delivers a binary hit that is not related to the system clock. The block brings every hit into the clock domain and turns each new hit into a pulse of programmable length. A channel can be silenced with a per-channel mask. The resulting stretched hit vector goes on to the latency buffer.

In parallel, the stretched and masked hits are reduced to a small number of sector bits for a fast trigger path. Each sector bit is the OR of one group of channels. A mode input selects how channels are grouped into sectors: contiguous blocks, or an interleaved stride. The sector bits are built combinationally from the registered stretched hits, so they are valid in the same clock cycle as the hit vector that feeds the buffer.

Top module: `hit_stretch_sector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `hits_o` and `sector_o` are all zero, whatever `hit_raw` does.
- R2: A rising edge on `hit_raw[i]` that is held over at least one rising clock edge makes `hits_o[i]` go high exactly three clock edges after the first edge that samples it. This assumes the channel is unmasked and idle.
- R3: The 3-bit `stretch_len_i` value N (0 to 7) keeps `hits_o[i]` high for exactly N+1 consecutive clock cycles after a single rising edge.
- R4: A hit level held high for many cycles starts only one stretch. It gives the same N+1 cycle pulse as a one-cycle hit.
- R5: A new rising edge on a channel whose stretch is still running restarts that channel's count. The output stays high until N+1 cycles after the later start, with no gap. Two edges that are further apart than the stretch give two separate pulses.
- R6: A channel whose `mask_i` bit is 1 never shows a 1 on `hits_o`.
- R7: A masked channel contributes nothing to `sector_o`.
- R8: With `group_mode_i` = 0, channel i drives sector i / (NCH/NSEC), so each sector covers a contiguous block of channels.
- R9: With `group_mode_i` = 1, channel i drives sector i mod NSEC, so each sector covers an interleaved set of channels.
- R10: `sector_o` reflects `hits_o` in the same clock cycle. A sector bit is high exactly when one of its unmasked channels is high on `hits_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_raw | input | NCH | Asynchronous per-channel discriminator hits |
| stretch_len_i | input | LEN_W | Stretch length minus one, in clock cycles |
| mask_i | input | NCH | Per-channel mask, 1 removes the channel |
| group_mode_i | input | 1 | Sector grouping: 0 contiguous, 1 interleaved |
| hits_o | output | NCH | Stretched, masked hits toward the latency buffer |
| sector_o | output | NSEC | Sector fast-OR bits |

## Verification
The bench builds the block with NCH = 16 and NSEC = 4, so each sector holds four channels. This keeps a complete sweep short. Every channel is pulsed at every one of the eight stretch lengths in both grouping modes. Each pulse's start cycle, length and sector target is compared with values computed from the channel index. At this size the bench can also cover, within a small run, a masked pulse on every channel, held levels, and retrigger gaps that fall both inside and outside the running stretch.

// File: rtl/hss_pkg.sv
// Package: shared types and constants for the hit stretcher / sector OR.
// Assumes nothing beyond standard SystemVerilog packages.
package hss_pkg;

    // Sector grouping selection.
    typedef enum logic {
        GROUP_BLOCK  = 1'b0,   // contiguous channels per sector
        GROUP_STRIDE = 1'b1    // channel i goes to sector i mod NSEC
    } group_mode_e;

    // Default width of the stretch-length field (lengths 1..2**LEN_W).
    localparam int unsigned DEF_LEN_W = 3;

endpackage

// File: rtl/hss_edge_sync.sv
// Module: hss_edge_sync
// Brings a vector of asynchronous hit levels into the clock domain with two
// flops per bit. It then emits a one-cycle start strobe on each rising edge.
// Assumes each input pulse spans at least one clock period so that it is seen.
module hss_edge_sync #(
    parameter int unsigned W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] start_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] last_q;

    // Purpose: two-stage synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Purpose: start strobe on a synchronised 0 -> 1 transition.
    always_comb begin
        start_o = sync_q & ~last_q;
    end

endmodule

// File: rtl/hss_stretch_cell.sv
// Module: hss_stretch_cell
// Single-channel retriggerable monostable. A start strobe holds the output
// high for len_i+1 cycles, and a new strobe reloads the count.
// Assumes len_i is stable while a stretch runs, or that a change is acceptable.
module hss_stretch_cell #(
    parameter int unsigned LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             active_o
);

    logic [LEN_W-1:0] remain_q;
    logic             active_q;

    // Purpose: load on start, count down while active, drop after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            remain_q <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            remain_q <= len_i;
        end else if (active_q) begin
            if (remain_q == '0) begin
                active_q <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    // Purpose: expose the stretched state.
    always_comb begin
        active_o = active_q;
    end

endmodule

// File: rtl/hss_sector_or.sv
// Module: hss_sector_or
// Reduces NCH hits to NSEC sector bits with either contiguous or interleaved
// grouping. The module is purely combinational.
// Assumes NCH is a whole multiple of NSEC.
module hss_sector_or
    import hss_pkg::*;
#(
    parameter int unsigned NCH  = 128,
    parameter int unsigned NSEC = 8
) (
    input  logic [NCH-1:0]  hits_i,
    input  group_mode_e     mode_i,
    output logic [NSEC-1:0] sector_o
);

    localparam int unsigned GRP = NCH / NSEC;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        logic [GRP-1:0] block_m;
        logic [GRP-1:0] stride_m;
        for (genvar k = 0; k < GRP; k++) begin : g_mem
            assign block_m[k]  = hits_i[s*GRP + k];
            assign stride_m[k] = hits_i[k*NSEC + s];
        end
        // Purpose: select the member set of this sector and OR it.
        always_comb begin
            sector_o[s] = (mode_i == GROUP_STRIDE) ? (|stride_m) : (|block_m);
        end
    end

endmodule

// File: rtl/hit_stretch_sector.sv
// Module: hit_stretch_sector (top)
// Synchronises NCH asynchronous hits and stretches each new hit for
// stretch_len_i+1 cycles. It applies the per-channel mask and builds NSEC
// sector fast-OR bits in the same cycle as the stretched hit vector.
// Assumes NCH is a whole multiple of NSEC and that configuration is quasi-static.
module hit_stretch_sector
    import hss_pkg::*;
#(
    parameter int unsigned NCH   = 128,
    parameter int unsigned NSEC  = 8,
    parameter int unsigned LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   hit_raw,
    input  logic [LEN_W-1:0] stretch_len_i,
    input  logic [NCH-1:0]   mask_i,
    input  logic             group_mode_i,
    output logic [NCH-1:0]   hits_o,
    output logic [NSEC-1:0]  sector_o
);

    logic [NCH-1:0] start_s;
    logic [NCH-1:0] stretched;
    group_mode_e    mode_s;

    hss_edge_sync #(.W(NCH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (hit_raw),
        .start_o (start_s)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        hss_stretch_cell #(.LEN_W(LEN_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start_s[i]),
            .len_i    (stretch_len_i),
            .active_o (stretched[i])
        );
    end

    // Purpose: apply the mask and decode the grouping mode.
    always_comb begin
        hits_o = stretched & ~mask_i;
        mode_s = group_mode_e'(group_mode_i);
    end

    hss_sector_or #(.NCH(NCH), .NSEC(NSEC)) u_or (
        .hits_i   (hits_o),
        .mode_i   (mode_s),
        .sector_o (sector_o)
    );

endmodule

// File: rtl/hss_checker.sv
// Module: hss_checker
// Property checker bound to hit_stretch_sector. It observes the ports and the
// unmasked stretched vector.
// Assumes a synchronous active-low reset.
module hss_checker #(
    parameter int unsigned NCH  = 128,
    parameter int unsigned NSEC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCH-1:0]  hit_raw,
    input logic [NCH-1:0]  mask_i,
    input logic [NCH-1:0]  stretched,
    input logic [NCH-1:0]  hits_o,
    input logic [NSEC-1:0] sector_o
);

    // R1: reset clears both outputs by the next cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (hits_o == '0 && sector_o == '0));

    // R6: a masked channel never shows on the hit vector.
    assert_mask_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hits_o & mask_i) == '0);

    // R7: with no hit visible, no sector bit is set.
    assert_sector_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hits_o == '0) |-> (sector_o == '0));

    // R10: any visible hit lights at least one sector in the same cycle.
    assert_sector_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hits_o != '0) |-> (sector_o != '0));

    // R10: sector count can never exceed the hit count.
    assert_sector_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sector_o) <= $countones(hits_o));

    for (genvar i = 0; i < NCH; i++) begin : g_lat
        // R2: a stretch only starts three edges after the raw hit was sampled high.
        assert_start_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stretched[i]) |-> $past(hit_raw[i], 3));
    end

endmodule

bind hit_stretch_sector hss_checker #(.NCH(NCH), .NSEC(NSEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_raw   (hit_raw),
    .mask_i    (mask_i),
    .stretched (stretched),
    .hits_o    (hits_o),
    .sector_o  (sector_o)
);

// File: tb/sim_hit_stretch_sector.sv
// Bench: exhaustive sweep over a 16-channel, 4-sector build.
module sim_hit_stretch_sector;

    localparam int NCH  = 16;
    localparam int NSEC = 4;
    localparam int GRP  = NCH / NSEC;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NCH-1:0]  hit_raw;
    logic [2:0]      stretch_len;
    logic [NCH-1:0]  mask;
    logic            group_mode;
    logic [NCH-1:0]  hits_o;
    logic [NSEC-1:0] sector_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    hit_stretch_sector #(.NCH(NCH), .NSEC(NSEC), .LEN_W(3)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .hit_raw       (hit_raw),
        .stretch_len_i (stretch_len),
        .mask_i        (mask),
        .group_mode_i  (group_mode),
        .hits_o        (hits_o),
        .sector_o      (sector_o)
    );

    // One pulse sequence on channel ch. Starts are at step 0 and, if gap > 0,
    // also at step gap. The first start holds for width steps. The hit check
    // and the sector check are each counted once per trial.
    task automatic trial(input int ch, input int len, input bit mode, input bit msk,
                         input int gap, input int width, input string htag, input string stag);
        bit hbad = 0;
        bit sbad = 0;
        logic [NCH-1:0]  h_act = '0, h_exp = '0;
        logic [NSEC-1:0] s_act = '0, s_exp = '0;
        int sec;
        hit_raw     = '0;
        stretch_len = 3'(len);
        group_mode  = mode;
        mask        = msk ? (NCH'(1) << ch) : '0;
        sec         = mode ? (ch % NSEC) : (ch / GRP);
        repeat (12) @(negedge clk);
        for (int n = 0; n < 24; n++) begin
            bit on;
            logic [NCH-1:0]  eh;
            logic [NSEC-1:0] es;
            @(negedge clk);
            on = (n >= 3 && n <= 3 + len) || (gap > 0 && n >= gap + 3 && n <= gap + 3 + len);
            eh = (on && !msk) ? (NCH'(1) << ch) : '0;
            es = (eh != '0) ? (NSEC'(1) << sec) : '0;
            if (hits_o !== eh && !hbad) begin
                hbad = 1; h_act = hits_o; h_exp = eh;
            end
            if (sector_o !== es && !sbad) begin
                sbad = 1; s_act = sector_o; s_exp = es;
            end
            hit_raw[ch] = (n < width) || (gap > 0 && n == gap);
        end
        checks += 2;
        if (hbad) begin
            fails++;
            $display("FAIL %s ch=%0d len=%0d hits act=%h exp=%h", htag, ch, len, h_act, h_exp);
        end
        if (sbad) begin
            fails++;
            $display("FAIL %s ch=%0d mode=%0d sector act=%h exp=%h", stag, ch, mode, s_act, s_exp);
        end
    endtask

    initial begin
        rst_n = 1'b0; hit_raw = '1; mask = '0; stretch_len = 3'd7; group_mode = 1'b0;
        repeat (5) @(negedge clk);
        checks++;
        if (hits_o !== '0 || sector_o !== '0) begin
            fails++;
            $display("FAIL R1 in reset act=%h/%h exp=0/0", hits_o, sector_o);
        end
        hit_raw = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        checks++;
        if (hits_o !== '0 || sector_o !== '0) begin
            fails++;
            $display("FAIL R1 after release act=%h/%h exp=0/0", hits_o, sector_o);
        end

        // R2 R3 R8 R9 R10: every channel, every length, both groupings.
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < NCH; c++)
                for (int l = 0; l < 8; l++)
                    trial(c, l, m[0], 1'b0, 0, 1, "R2_R3",
                          (m == 0) ? "R8_R10" : "R9_R10");

        // R6 R7: masked pulse on every channel.
        for (int c = 0; c < NCH; c++)
            trial(c, 5, c[0], 1'b1, 0, 1, "R6", "R7");

        // R4: level held well beyond the stretch.
        for (int l = 0; l < 8; l++)
            trial(l, l, 1'b0, 1'b0, 0, 12, "R4", "R4_R8");

        // R5: second edge inside the stretch and outside it.
        for (int l = 0; l < 8; l++)
            for (int g = 2; g <= 8; g += 2)
                trial(15 - l, l, 1'b1, 1'b0, g, 1, "R5", "R5_R9");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule